// File: doc/BRIEF.md
# Shared-Pin Request/Grant Bus Arbiter

This block sits on the side of a bus owner that can give its bus away to up to two external requesters. Each requester shares one bidirectional line with the owner, modelled here as a separate input, output and output-enable. A requester pulses the line for one clock to ask for the bus. The owner then waits for its current bus cycle to end, which is marked by the `cycle_end` input. It answers with a one-clock grant pulse on the same line and withdraws from the bus. A second one-clock pulse from the requester on that line hands the bus back.

A second handshake style is also provided. When `hold_mode` is high while the arbiter is idle, a level request on `hold_in` is answered on `hlda_out` after the current bus cycle ends, and the shared lines are not used. `bus_free` tells the owner's own bus logic whether it may use the bus.

The controller has seven states. IDLE moves to WAIT on a line pulse, or to HWAIT on `hold_in` in hold mode. WAIT moves to GRANT on `cycle_end`. GRANT always moves to HELD. HELD moves to REL on the owner's release pulse. REL moves to WAIT when a request is still pending and to IDLE otherwise. HWAIT moves to HACK on `cycle_end` and back to IDLE if `hold_in` drops. HACK moves to IDLE when `hold_in` drops.

Top module: `rqgt_arbiter`

## Requirements
- R1: After reset, `bus_free` is 1, `rg_oe`, `rg_out` and `hlda_out` are all 0, and no request is pending.
- R2: A one-clock high on `rg_in[i]` in line mode records a request. No grant appears until `cycle_end` has been sampled high while the request waits. The grant appears in the cycle after that sample.
- R3: A grant is exactly one clock long, with `rg_oe[i]` and `rg_out[i]` both 1 on the granted line only. At all other times `rg_oe` is all zeros.
- R4: When requests from line 0 and line 1 are both pending at the grant decision, line 0 (bit 0) is granted first.
- R5: `bus_free` is 0 from the grant cycle through the cycle after the release pulse is sampled on the owning line, and 1 again in the cycle after that.
- R6: A request pulse on the other line while the bus is granted or held is remembered. After the release it is served through WAIT, and it again waits for `cycle_end`.
- R7: In hold mode, `hold_in` high, followed by a sampled `cycle_end`, raises `hlda_out` in the next cycle. `hlda_out` stays 1 while `hold_in` stays 1 and falls in the cycle after `hold_in` is sampled low. `bus_free` is 0 exactly while `hlda_out` is 1.
- R8: While idle with `hold_mode` = 1, pulses on `rg_in` are ignored: no grant is driven and `bus_free` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_mode | input | 1 | 1 selects the level hold/acknowledge handshake; sampled in IDLE |
| cycle_end | input | 1 | High in the last clock of the owner's current bus cycle |
| rg_in | input | NPIN | Line inputs: one-clock request or release pulses |
| rg_out | output | NPIN | Line output value (grant pulse) |
| rg_oe | output | NPIN | Line output enable, high only during a grant |
| hold_in | input | 1 | Level bus request in hold mode |
| hlda_out | output | 1 | Hold acknowledge in hold mode |
| bus_free | output | 1 | 1 when the owner may use the bus |

## Verification
On every cycle, the assertions check that at most one line is driven and only for one clock. They also check that a grant or acknowledge follows a sampled `cycle_end`, that the two handshakes never overlap, and that `bus_free` is low whenever the bus is given away. Only the bench scenarios can show the release timing, the fixed ordering between lines, the deferred service of a request that arrives while the bus is held, and that line pulses are ignored in hold mode. The bench runs a cycle-level reference model alongside directed sequences and a seeded random mix.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GRANT,
        ST_HELD,
        ST_REL,
        ST_HWAIT,
        ST_HACK
    } arb_state_e;
endpackage

// File: rtl/rqgt_pend.sv
// Pending-request register: bits set by incoming pulses, cleared on grant.
module rqgt_pend #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] set_mask,
    input  logic [NPIN-1:0] clr_mask,
    output logic [NPIN-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend | set_mask) & ~clr_mask;
        end
    end

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_keep
            // R6
            pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[g] && !clr_mask[g]) |=> pend[g]);
        end
    endgenerate
endmodule

// File: rtl/rqgt_pick.sv
// Fixed-priority picker: lowest index wins.
module rqgt_pick #(
    parameter int NPIN = 2,
    localparam int IW = $clog2(NPIN)
) (
    input  logic [NPIN-1:0] req,
    output logic [NPIN-1:0] gnt,
    output logic [IW-1:0]   idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int k = NPIN - 1; k >= 0; k--) begin
            if (req[k]) begin
                gnt = '0;
                gnt[k] = 1'b1;
                idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/rqgt_drive.sv
// Per-line output driver: drives the grant pulse on the owning line only.
module rqgt_drive #(
    parameter int NPIN = 2,
    localparam int IW = $clog2(NPIN)
) (
    input  logic            en,
    input  logic [IW-1:0]   owner,
    output logic [NPIN-1:0] rg_out,
    output logic [NPIN-1:0] rg_oe
);
    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_line
            assign rg_oe[g]  = en && (owner == IW'(g));
            assign rg_out[g] = en && (owner == IW'(g));
        end
    endgenerate
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
    import rqgt_pkg::*;
#(
    parameter int NPIN = 2,
    localparam int IW = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_mode,
    input  logic            cycle_end,
    input  logic [NPIN-1:0] rg_in,
    output logic [NPIN-1:0] rg_out,
    output logic [NPIN-1:0] rg_oe,
    input  logic            hold_in,
    output logic            hlda_out,
    output logic            bus_free
);
    arb_state_e      st_q, st_n;
    logic [IW-1:0]   owner_q, owner_n;
    logic [NPIN-1:0] pend, set_mask, clr_mask, own_mask, cand, win;
    logic [IW-1:0]   win_idx;
    logic            drive_en;

    assign own_mask = NPIN'(1) << owner_q;
    assign cand     = pend | rg_in;

    rqgt_pend #(.NPIN(NPIN)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend)
    );

    rqgt_pick #(.NPIN(NPIN)) u_pick (
        .req(cand), .gnt(win), .idx(win_idx)
    );

    rqgt_drive #(.NPIN(NPIN)) u_drive (
        .en(drive_en), .owner(owner_q), .rg_out(rg_out), .rg_oe(rg_oe)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            owner_q <= '0;
        end else begin
            st_q    <= st_n;
            owner_q <= owner_n;
        end
    end

    // Next state and pending-mask control
    always_comb begin
        st_n     = st_q;
        owner_n  = owner_q;
        set_mask = '0;
        clr_mask = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_mode) begin
                    if (hold_in) st_n = ST_HWAIT;
                end else if (|rg_in) begin
                    set_mask = rg_in;
                    st_n     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                set_mask = rg_in;
                if (cycle_end) begin
                    clr_mask = win;
                    owner_n  = win_idx;
                    st_n     = ST_GRANT;
                end
            end
            ST_GRANT: begin
                set_mask = rg_in & ~own_mask;
                st_n     = ST_HELD;
            end
            ST_HELD: begin
                set_mask = rg_in & ~own_mask;
                if (|(rg_in & own_mask)) st_n = ST_REL;
            end
            ST_REL: begin
                set_mask = rg_in;
                st_n     = (|cand) ? ST_WAIT : ST_IDLE;
            end
            ST_HWAIT: begin
                if (!hold_in)       st_n = ST_IDLE;
                else if (cycle_end) st_n = ST_HACK;
            end
            ST_HACK: begin
                if (!hold_in) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        drive_en = 1'b0;
        hlda_out = 1'b0;
        bus_free = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_WAIT, ST_HWAIT: bus_free = 1'b1;
            ST_GRANT:                   drive_en = 1'b1;
            ST_HACK:                    hlda_out = 1'b1;
            default:                    ;
        endcase
    end

    // R3
    line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rg_oe));
    // R3
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |=> !(|rg_oe));
    // R3
    out_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_out & ~rg_oe) == '0);
    // R2
    grant_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |-> $past(cycle_end));
    // R7
    hlda_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_out) |-> $past(cycle_end) && $past(hold_in));
    // R7
    handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hlda_out && (|rg_oe)));
    // R5
    free_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda_out || (|rg_oe)) |-> !bus_free);
    // R5
    grant_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |=> !bus_free);
endmodule

// File: tb/test_rqgt_arbiter.sv
`timescale 1ns/1ps
module test_rqgt_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_mode = 1'b0;
    logic       cycle_end = 1'b0;
    logic [1:0] rg_in = 2'b00;
    logic [1:0] rg_out, rg_oe;
    logic       hold_in = 1'b0;
    logic       hlda_out, bus_free;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state: 0 idle,1 wait,2 grant,3 held,4 release,5 hold wait,6 hold ack
    int         m_st = 0;
    int         m_own = 0;
    logic [1:0] m_pend = 2'b00;

    always #2.5 clk = ~clk;

    rqgt_arbiter i_rqgt_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .cycle_end(cycle_end),
        .rg_in(rg_in), .rg_out(rg_out), .rg_oe(rg_oe),
        .hold_in(hold_in), .hlda_out(hlda_out), .bus_free(bus_free)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] own_mask(int o);
        return (o == 0) ? 2'b01 : 2'b10;
    endfunction

    function automatic int exp_free();
        return (m_st == 0 || m_st == 1 || m_st == 5) ? 1 : 0;
    endfunction

    function automatic int exp_oe();
        return (m_st == 2) ? int'(own_mask(m_own)) : 0;
    endfunction

    task automatic model_step(logic [1:0] rin, logic ce, logic hin, logic hm);
        logic [1:0] all;
        logic [1:0] om;
        om = own_mask(m_own);
        case (m_st)
            0: if (hm) begin
                   if (hin) m_st = 5;
               end else if (rin != 0) begin
                   m_pend = m_pend | rin; m_st = 1;
               end
            1: begin
                   all = m_pend | rin;
                   if (ce) begin
                       m_own = all[0] ? 0 : 1;
                       m_pend = all & ~own_mask(m_own);
                       m_st = 2;
                   end else m_pend = all;
               end
            2: begin m_pend = m_pend | (rin & ~om); m_st = 3; end
            3: begin
                   m_pend = m_pend | (rin & ~om);
                   if ((rin & om) != 0) m_st = 4;
               end
            4: begin m_pend = m_pend | rin; m_st = (m_pend != 0) ? 1 : 0; end
            5: if (!hin) m_st = 0; else if (ce) m_st = 6;
            6: if (!hin) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    // Apply inputs for one clock, advance the model, compare at the next falling edge.
    task automatic step(logic [1:0] rin, logic ce, logic hin, logic hm);
        rg_in = rin; cycle_end = ce; hold_in = hin; hold_mode = hm;
        @(posedge clk);
        model_step(rin, ce, hin, hm);
        @(negedge clk);
        check("R3 rg_oe", int'(rg_oe), exp_oe());
        check("R3 rg_out", int'(rg_out), exp_oe());
        check("R5 bus_free", int'(bus_free), exp_free());
        check("R7 hlda_out", int'(hlda_out), (m_st == 6) ? 1 : 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic hm_r;
        logic hin_r;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 bus_free", int'(bus_free), 1);
        check("R1 rg_oe", int'(rg_oe), 0);
        check("R1 rg_out", int'(rg_out), 0);
        check("R1 hlda_out", int'(hlda_out), 0);

        // R2: request on line 1 waits for cycle_end
        step(2'b10, 0, 0, 0);
        repeat (3) begin
            step(2'b00, 0, 0, 0);
            check("R2 no grant before cycle_end", int'(rg_oe), 0);
        end
        step(2'b00, 1, 0, 0);
        check("R2 grant after cycle_end", int'(rg_oe), 2);
        step(2'b00, 0, 0, 0);
        check("R3 grant one clock", int'(rg_oe), 0);
        // R5: release on line 1
        step(2'b10, 0, 0, 0);
        check("R5 free low after release", int'(bus_free), 0);
        step(2'b00, 0, 0, 0);
        check("R5 free high one clock later", int'(bus_free), 1);

        // R4: both lines together, line 0 first
        step(2'b11, 0, 0, 0);
        step(2'b00, 1, 0, 0);
        check("R4 line 0 wins", int'(rg_oe), 1);
        step(2'b00, 0, 0, 0);
        step(2'b01, 0, 0, 0);
        step(2'b00, 0, 0, 0);
        check("R6 pending line 1 waits", int'(rg_oe), 0);
        step(2'b00, 1, 0, 0);
        check("R4 line 1 served second", int'(rg_oe), 2);
        step(2'b00, 0, 0, 0);
        step(2'b10, 0, 0, 0);
        step(2'b00, 0, 0, 0);

        // R6: request from line 1 while line 0 holds the bus
        step(2'b01, 0, 0, 0);
        step(2'b00, 1, 0, 0);
        check("R6 line 0 granted", int'(rg_oe), 1);
        step(2'b00, 0, 0, 0);
        step(2'b10, 0, 0, 0);
        check("R6 no grant while held", int'(rg_oe), 0);
        step(2'b01, 0, 0, 0);
        step(2'b00, 0, 0, 0);
        check("R6 back in wait, bus free", int'(bus_free), 1);
        step(2'b00, 1, 0, 0);
        check("R6 deferred line 1 granted", int'(rg_oe), 2);
        step(2'b00, 0, 0, 0);
        step(2'b10, 0, 0, 0);
        step(2'b00, 0, 0, 0);

        // R8: line pulses ignored in hold mode
        step(2'b11, 0, 0, 1);
        step(2'b00, 1, 0, 1);
        check("R8 no grant in hold mode", int'(rg_oe), 0);
        check("R8 bus stays free", int'(bus_free), 1);
        step(2'b00, 1, 0, 1);
        check("R8 still no grant", int'(rg_oe), 0);

        // R7: hold handshake
        step(2'b00, 0, 1, 1);
        step(2'b00, 0, 1, 1);
        check("R7 no ack before cycle_end", int'(hlda_out), 0);
        step(2'b00, 1, 1, 1);
        check("R7 ack after cycle_end", int'(hlda_out), 1);
        check("R7 bus busy while ack", int'(bus_free), 0);
        step(2'b01, 0, 1, 1);
        check("R7 ack held", int'(hlda_out), 1);
        step(2'b00, 0, 0, 1);
        check("R7 ack dropped", int'(hlda_out), 0);
        check("R7 bus free again", int'(bus_free), 1);

        // Random mix checked against the model
        hm_r = 0;
        hin_r = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] rin;
            if ($urandom_range(0, 199) == 0) hm_r = ~hm_r;
            if ($urandom_range(0, 7) == 0) hin_r = ~hin_r;
            rin[0] = ($urandom_range(0, 5) == 0);
            rin[1] = ($urandom_range(0, 5) == 0);
            step(rin, ($urandom_range(0, 2) == 0), hin_r, hm_r);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule